// File: doc/BRIEF.md
# Vector Element Bit-Manipulation Unit

This block applies one bit-manipulation operation to a single vector element per cycle. The operations are aimed at cryptographic code. The element width is chosen at run time from 8, 16, 32 or 64 bits, so one datapath serves every lane width.

The operations are:
- and-not
- bit reverse within the element
- bit reverse within each byte
- byte reverse
- leading-zero count
- trailing-zero count
- population count
- rotate left
- rotate right
- widening logical shift left

The second operand has three possible sources: a vector element, a scalar, or a 6-bit immediate. The immediate arrives as two instruction fields.

A sequencer presents the inputs with a valid strobe. The registered result appears one cycle later with its own valid flag. Masking, vector length and register-file access stay with the surrounding pipeline.

Top module: `vbm_unit`

## Requirements
- R1: Op code 0 (and-not) returns the source element ANDed with the bitwise complement of the second operand.
- R2: Op code 2 reverses the bit order inside every byte of the element and leaves the byte order unchanged.
- R3: Op code 1 reverses the bit order of the whole element: element bit i moves to bit SEW-1-i.
- R4: Op code 3 reverses the byte order of the element; for 8-bit elements the element is returned unchanged.
- R5: Op code 4 counts leading zeros and op code 5 counts trailing zeros, both within SEW; an all-zero element yields SEW.
- R6: Op code 6 returns the number of set bits of the element, a value in the range 0 to SEW.
- R7: Op codes 7 (rotate left) and 8 (rotate right) rotate within SEW bits by the second operand modulo SEW.
- R8: Op code 9 zero-extends the element to 2*SEW bits and shifts it left by the second operand modulo 2*SEW; result bits at or above 2*SEW are zero.
- R9: Operand select 0 picks the vector operand and 1 picks the scalar. Either value with bit 1 set picks the immediate, built as an unsigned 6-bit value: its top bit is instruction bit 26 (in_imm_hi) and its low five bits are instruction bits 19:15 (in_imm_lo).
- R10: Width code 0/1/2/3 selects SEW 8/16/32/64. Source and operand bits at or above SEW are ignored. Every result bit at or above SEW is zero, except for op code 9.
- R11: out_valid equals in_valid of the previous cycle, and out_data holds the result of the inputs from that cycle. A synchronous low reset clears out_valid and out_data.
- R12: Op codes 10 to 15 produce an all-zero result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input strobe |
| in_op | input | 4 | Operation code |
| in_sew | input | SEW_W (2) | Element width code |
| in_src | input | ELEN | Source element |
| in_vec_b | input | ELEN | Vector second operand |
| in_scalar | input | ELEN | Scalar second operand |
| in_imm_lo | input | 5 | Immediate low bits (instruction bits 19:15) |
| in_imm_hi | input | 1 | Immediate top bit (instruction bit 26) |
| in_b_sel | input | 2 | Second operand source select |
| out_valid | output | 1 | Result valid |
| out_data | output | 2*ELEN | Result element |

## Verification
The bench builds the unit with its default ELEN of 64, so all four width codes are reachable, including the 64-bit rotate and the 128-bit widening shift. That choice exposes every byte-reorder stage of the reversal chain. It also brings into play the immediate rotate amounts above 31, which need the split top bit, and the shift amounts that wrap modulo 2*SEW.

// File: rtl/vbm_pkg.sv
// Shared definitions for the vector bit-manipulation unit.
// Assumes a 4-bit operation code; unlisted codes yield zero.
package vbm_pkg;

    typedef enum logic [3:0] {
        OP_ANDN  = 4'd0,
        OP_BREV  = 4'd1,
        OP_BREV8 = 4'd2,
        OP_REV8  = 4'd3,
        OP_CLZ   = 4'd4,
        OP_CTZ   = 4'd5,
        OP_CPOP  = 4'd6,
        OP_ROL   = 4'd7,
        OP_ROR   = 4'd8,
        OP_WSLL  = 4'd9
    } vbm_op_e;

    localparam int unsigned IMM_W = 6;

    // Join the split immediate: top bit from instruction bit 26, rest from 19:15.
    function automatic logic [IMM_W-1:0] join_imm(input logic hi, input logic [4:0] lo);
        return {hi, lo};
    endfunction

endpackage

// File: rtl/vbm_permute.sv
// Bit and byte permutations of one element.
// Each permutation stage moves bit i to bit i XOR d. Stages with d = 1, 2 and 4
// reverse the bits inside each byte. Stages with d = 8, 16, ... reorder the bytes,
// and each turns on only when the element is wider than d.
// Assumes the source is already masked to the element width.
module vbm_permute #(
    parameter int unsigned ELEN = 64,
    localparam int unsigned NR    = $clog2(ELEN / 8),
    localparam int unsigned SEW_W = (NR > 0) ? $clog2(NR + 1) : 1
) (
    input  logic [ELEN-1:0]  src,
    input  logic [SEW_W-1:0] sew,
    output logic [ELEN-1:0]  brev8_o,
    output logic [ELEN-1:0]  brev_o,
    output logic [ELEN-1:0]  rev8_o
);

    // Move every bit i to position i XOR d.
    function automatic logic [ELEN-1:0] xswap(input logic [ELEN-1:0] v, input int unsigned d);
        logic [ELEN-1:0] r;
        for (int i = 0; i < ELEN; i++) r[i] = v[i ^ d];
        return r;
    endfunction

    logic [ELEN-1:0] bits_chain [0:NR];
    logic [ELEN-1:0] byte_chain [0:NR];

    // Per-byte reversal in three swap stages: bits, then pairs, then nibbles.
    assign brev8_o       = xswap(xswap(xswap(src, 1), 2), 4);
    assign bits_chain[0] = brev8_o;
    assign byte_chain[0] = src;

    genvar k;
    generate
        for (k = 0; k < NR; k++) begin : g_reorder
            localparam int unsigned D = 8 << k;
            // Reorder stage k, active only when the element is wider than D bits.
            assign bits_chain[k+1] = (int'(sew) > k) ? xswap(bits_chain[k], D) : bits_chain[k];
            assign byte_chain[k+1] = (int'(sew) > k) ? xswap(byte_chain[k], D) : byte_chain[k];
        end
    endgenerate

    assign brev_o = bits_chain[NR];
    assign rev8_o = byte_chain[NR];

endmodule

// File: rtl/vbm_count.sv
// Leading-zero, trailing-zero and population counts within the element width.
// Assumes the source is already masked to the element width.
// An all-zero element yields the element width for both zero counts.
module vbm_count #(
    parameter int unsigned ELEN = 64,
    localparam int unsigned NR    = $clog2(ELEN / 8),
    localparam int unsigned SEW_W = (NR > 0) ? $clog2(NR + 1) : 1,
    localparam int unsigned CNT_W = $clog2(ELEN) + 1
) (
    input  logic [ELEN-1:0]  src,
    input  logic [SEW_W-1:0] sew,
    output logic [CNT_W-1:0] clz_o,
    output logic [CNT_W-1:0] ctz_o,
    output logic [CNT_W-1:0] cpop_o
);

    int unsigned ew;

    // Element width in bits from the width code.
    always_comb ew = 8 << sew;

    // Leading zeros: the highest set bit below ew wins.
    always_comb begin
        clz_o = CNT_W'(ew);
        for (int i = 0; i < ELEN; i++)
            if (i < ew && src[i]) clz_o = CNT_W'(ew - 1 - i);
    end

    // Trailing zeros: the lowest set bit wins.
    always_comb begin
        ctz_o = CNT_W'(ew);
        for (int i = ELEN - 1; i >= 0; i--)
            if (src[i]) ctz_o = CNT_W'(i);
    end

    // Population count of the masked element.
    always_comb begin
        cpop_o = '0;
        for (int i = 0; i < ELEN; i++) cpop_o = cpop_o + CNT_W'(src[i]);
    end

endmodule

// File: rtl/vbm_shift.sv
// Rotates and the widening shift for every element width.
// One lane is built per width, and the width code picks a lane.
// Rotates use amt modulo SEW; the widening shift uses amt modulo 2*SEW.
module vbm_shift #(
    parameter int unsigned ELEN = 64,
    localparam int unsigned NR    = $clog2(ELEN / 8),
    localparam int unsigned NSEW  = NR + 1,
    localparam int unsigned SEW_W = (NR > 0) ? $clog2(NSEW) : 1,
    localparam int unsigned SH_W  = $clog2(ELEN) + 1
) (
    input  logic [ELEN-1:0]   src,
    input  logic [SH_W-1:0]   amt,
    input  logic [SEW_W-1:0]  sew,
    output logic [ELEN-1:0]   rol_o,
    output logic [ELEN-1:0]   ror_o,
    output logic [2*ELEN-1:0] wsll_o
);

    logic [ELEN-1:0]   rol_a  [NSEW];
    logic [ELEN-1:0]   ror_a  [NSEW];
    logic [2*ELEN-1:0] wsll_a [NSEW];

    genvar k;
    generate
        for (k = 0; k < NSEW; k++) begin : g_lane
            localparam int unsigned W  = 8 << k;
            localparam int unsigned AW = $clog2(W);
            logic [W-1:0]   lane;
            logic [2*W-1:0] dbl, rl, rr, wide;
            assign lane = src[W-1:0];
            assign dbl  = {lane, lane};
            assign rl   = dbl << amt[AW-1:0];
            assign rr   = dbl >> amt[AW-1:0];
            assign wide = {{W{1'b0}}, lane} << amt[AW:0];
            assign rol_a[k]  = ELEN'(rl[2*W-1:W]);
            assign ror_a[k]  = ELEN'(rr[W-1:0]);
            assign wsll_a[k] = (2*ELEN)'(wide);
        end
    endgenerate

    // Pick the lane that matches the width code.
    always_comb begin
        rol_o  = '0;
        ror_o  = '0;
        wsll_o = '0;
        for (int i = 0; i < NSEW; i++)
            if (int'(sew) == i) begin
                rol_o  = rol_a[i];
                ror_o  = ror_a[i];
                wsll_o = wsll_a[i];
            end
    end

endmodule

// File: rtl/vbm_unit.sv
// Top of the vector element bit-manipulation unit.
// Masks the inputs to the selected width and picks the second operand.
// Runs one operation and registers the result, with one cycle of latency.
// Assumes ELEN is a power of two, at least 8.
module vbm_unit #(
    parameter int unsigned ELEN = 64,
    localparam int unsigned NR    = $clog2(ELEN / 8),
    localparam int unsigned SEW_W = (NR > 0) ? $clog2(NR + 1) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [3:0]        in_op,
    input  logic [SEW_W-1:0]  in_sew,
    input  logic [ELEN-1:0]   in_src,
    input  logic [ELEN-1:0]   in_vec_b,
    input  logic [ELEN-1:0]   in_scalar,
    input  logic [4:0]        in_imm_lo,
    input  logic              in_imm_hi,
    input  logic [1:0]        in_b_sel,
    output logic              out_valid,
    output logic [2*ELEN-1:0] out_data
);
    import vbm_pkg::*;

    localparam int unsigned CNT_W = $clog2(ELEN) + 1;
    localparam int unsigned SH_W  = $clog2(ELEN) + 1;

    int unsigned       ew;
    logic [ELEN-1:0]   elem_mask, src_m, b_raw, b_m;
    logic [ELEN-1:0]   brev8_w, brev_w, rev8_w, rol_w, ror_w;
    logic [2*ELEN-1:0] wsll_w, res;
    logic [CNT_W-1:0]  clz_w, ctz_w, cpop_w;

    // Mask of the bits that belong to the selected element width.
    always_comb begin
        ew = 8 << in_sew;
        for (int i = 0; i < ELEN; i++) elem_mask[i] = (i < ew);
    end

    // Second operand source: bit 1 picks the immediate, else bit 0 picks the scalar.
    always_comb begin
        if (in_b_sel[1])      b_raw = ELEN'(join_imm(in_imm_hi, in_imm_lo));
        else if (in_b_sel[0]) b_raw = in_scalar;
        else                  b_raw = in_vec_b;
    end

    assign src_m = in_src & elem_mask;
    assign b_m   = b_raw & elem_mask;

    vbm_permute #(.ELEN(ELEN)) perm_i (
        .src(src_m), .sew(in_sew),
        .brev8_o(brev8_w), .brev_o(brev_w), .rev8_o(rev8_w)
    );

    vbm_count #(.ELEN(ELEN)) cnt_i (
        .src(src_m), .sew(in_sew),
        .clz_o(clz_w), .ctz_o(ctz_w), .cpop_o(cpop_w)
    );

    vbm_shift #(.ELEN(ELEN)) shf_i (
        .src(src_m), .amt(b_m[SH_W-1:0]), .sew(in_sew),
        .rol_o(rol_w), .ror_o(ror_w), .wsll_o(wsll_w)
    );

    // Result select by operation code; unlisted codes give zero.
    always_comb begin
        case (in_op)
            OP_ANDN:  res = (2*ELEN)'(src_m & ~b_m & elem_mask);
            OP_BREV:  res = (2*ELEN)'(brev_w);
            OP_BREV8: res = (2*ELEN)'(brev8_w);
            OP_REV8:  res = (2*ELEN)'(rev8_w);
            OP_CLZ:   res = (2*ELEN)'(clz_w);
            OP_CTZ:   res = (2*ELEN)'(ctz_w);
            OP_CPOP:  res = (2*ELEN)'(cpop_w);
            OP_ROL:   res = (2*ELEN)'(rol_w);
            OP_ROR:   res = (2*ELEN)'(ror_w);
            OP_WSLL:  res = wsll_w;
            default:  res = '0;
        endcase
    end

    // Output register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= in_valid;
            out_data  <= res;
        end
    end

endmodule

// File: rtl/vbm_unit_chk.sv
// Property checker for vbm_unit, attached with bind.
// Assumes in_sew and in_op are sampled in the cycle that precedes the result.
module vbm_unit_chk #(
    parameter int unsigned ELEN = 64,
    localparam int unsigned NR    = $clog2(ELEN / 8),
    localparam int unsigned SEW_W = (NR > 0) ? $clog2(NR + 1) : 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [3:0]        in_op,
    input logic [SEW_W-1:0]  in_sew,
    input logic              out_valid,
    input logic [2*ELEN-1:0] out_data
);

    // R11
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R11
    idle_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R11
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && out_data == '0));

    // R5 R6
    count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (in_op == 4'd4 || in_op == 4'd5 || in_op == 4'd6))
        |=> out_data <= (2*ELEN)'(8 << $past(in_sew)));

    // R10
    upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op != 4'd9) |=> (out_data >> (8 << $past(in_sew))) == '0);

    // R8
    wide_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op == 4'd9) |=> (out_data >> (16 << $past(in_sew))) == '0);

endmodule

bind vbm_unit vbm_unit_chk #(.ELEN(ELEN)) chk_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
    .in_sew(in_sew), .out_valid(out_valid), .out_data(out_data)
);

// File: tb/vbm_unit_tb_top.sv
`timescale 1ns/1ps
module vbm_unit_tb_top;

    typedef struct packed {
        logic [3:0]   op;
        logic [1:0]   sew;
        logic [1:0]   bsel;
        logic [63:0]  a;
        logic [63:0]  vb;
        logic [63:0]  xs;
        logic [5:0]   imm;   // {instruction bit 26, instruction bits 19:15}
        logic [127:0] exp;
    } vec_t;

    localparam int NV = 27;
    localparam vec_t VECS [NV] = '{
        // R1 and-not, 64-bit
        '{4'd0, 2'd3, 2'd0, 64'hFFFF_0000_F0F0_1234, 64'h0F0F_0F0F_FFFF_0034, 64'h0, 6'h0, 128'hF0F0_0000_0000_1200},
        // R1 R10 and-not, 8-bit, upper source bits ignored
        '{4'd0, 2'd0, 2'd0, 64'hFFFF_FFFF_FFFF_FFAB, 64'h0F, 64'h0, 6'h0, 128'hA0},
        // R2 per-byte reversal
        '{4'd2, 2'd3, 2'd0, 64'h0102_0408_1020_4080, 64'h0, 64'h0, 6'h0, 128'h8040_2010_0804_0201},
        // R3 full reversal at 64, 16 and 32 bits
        '{4'd1, 2'd3, 2'd0, 64'h1, 64'h0, 64'h0, 6'h0, 128'h8000_0000_0000_0000},
        '{4'd1, 2'd1, 2'd0, 64'h1, 64'h0, 64'h0, 6'h0, 128'h8000},
        '{4'd1, 2'd2, 2'd0, 64'hF1, 64'h0, 64'h0, 6'h0, 128'h8F00_0000},
        // R4 byte reverse at 32, 8 and 64 bits
        '{4'd3, 2'd2, 2'd0, 64'h1122_3344, 64'h0, 64'h0, 6'h0, 128'h4433_2211},
        '{4'd3, 2'd0, 2'd0, 64'h5A, 64'h0, 64'h0, 6'h0, 128'h5A},
        '{4'd3, 2'd3, 2'd0, 64'h0102_0304_0506_0708, 64'h0, 64'h0, 6'h0, 128'h0807_0605_0403_0201},
        // R5 leading and trailing zero counts, zero inputs give SEW
        '{4'd4, 2'd2, 2'd0, 64'h0001_0000, 64'h0, 64'h0, 6'h0, 128'd15},
        '{4'd4, 2'd3, 2'd0, 64'h0, 64'h0, 64'h0, 6'h0, 128'd64},
        '{4'd5, 2'd1, 2'd0, 64'h0, 64'h0, 64'h0, 6'h0, 128'd16},
        '{4'd5, 2'd3, 2'd0, 64'h8000_0000_0000_0000, 64'h0, 64'h0, 6'h0, 128'd63},
        // R5 R10 upper bits ignored, 8-bit element is zero
        '{4'd4, 2'd0, 2'd0, 64'hFF00, 64'h0, 64'h0, 6'h0, 128'd8},
        // R6 population count
        '{4'd6, 2'd3, 2'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 64'h0, 6'h0, 128'd64},
        '{4'd6, 2'd1, 2'd0, 64'hFFFF_0F0F, 64'h0, 64'h0, 6'h0, 128'd8},
        // R7 rotates, amount modulo SEW
        '{4'd7, 2'd0, 2'd0, 64'h81, 64'd1, 64'h0, 6'h0, 128'h03},
        '{4'd7, 2'd1, 2'd0, 64'h8001, 64'd17, 64'h0, 6'h0, 128'h0003},
        '{4'd8, 2'd2, 2'd0, 64'h1, 64'd4, 64'h0, 6'h0, 128'h1000_0000},
        // R9 immediate rotate amount 33 (top bit set)
        '{4'd8, 2'd3, 2'd2, 64'h1, 64'h0, 64'h0, 6'h21, 128'h8000_0000},
        // R9 scalar operand
        '{4'd8, 2'd3, 2'd1, 64'hF, 64'h0, 64'd4, 6'h0, 128'hF000_0000_0000_0000},
        // R9 R7 immediate 63 at 8 bits acts as 7
        '{4'd8, 2'd0, 2'd3, 64'h1, 64'h0, 64'h0, 6'h3F, 128'h02},
        // R8 widening shifts
        '{4'd9, 2'd0, 2'd0, 64'hFF, 64'd4, 64'h0, 6'h0, 128'h0FF0},
        '{4'd9, 2'd3, 2'd0, 64'h8000_0000_0000_0001, 64'd64, 64'h0, 6'h0, 128'h8000_0000_0000_0001_0000_0000_0000_0000},
        '{4'd9, 2'd1, 2'd0, 64'hFFFF, 64'd33, 64'h0, 6'h0, 128'h1_FFFE},
        // R12 unlisted code
        '{4'd12, 2'd3, 2'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 64'h0, 6'h0, 128'h0},
        // R10 upper operand bits ignored in and-not
        '{4'd0, 2'd0, 2'd0, 64'h3C, 64'hFFFF_FFFF_FFFF_FF00, 64'h0, 6'h0, 128'h3C}
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [3:0]   in_op = '0;
    logic [1:0]   in_sew = '0;
    logic [63:0]  in_src = '0, in_vec_b = '0, in_scalar = '0;
    logic [4:0]   in_imm_lo = '0;
    logic         in_imm_hi = 1'b0;
    logic [1:0]   in_b_sel = '0;
    logic         out_valid;
    logic [127:0] out_data;
    int           n_chk = 0;
    int           n_bad = 0;
    bit           done = 1'b0;

    always #2.5 clk = ~clk;

    vbm_unit dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op), .in_sew(in_sew),
        .in_src(in_src), .in_vec_b(in_vec_b), .in_scalar(in_scalar),
        .in_imm_lo(in_imm_lo), .in_imm_hi(in_imm_hi), .in_b_sel(in_b_sel),
        .out_valid(out_valid), .out_data(out_data)
    );

    function automatic string tag_of(input logic [3:0] op);
        case (op)
            4'd0: return "R1";
            4'd1: return "R3";
            4'd2: return "R2";
            4'd3: return "R4";
            4'd4, 4'd5: return "R5";
            4'd6: return "R6";
            4'd7, 4'd8: return "R7";
            4'd9: return "R8";
            default: return "R12";
        endcase
    endfunction

    task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        in_op     = v.op;
        in_sew    = v.sew;
        in_b_sel  = v.bsel;
        in_src    = v.a;
        in_vec_b  = v.vb;
        in_scalar = v.xs;
        in_imm_hi = v.imm[5];
        in_imm_lo = v.imm[4:0];
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11 reset state
        check("R11", {127'd0, out_valid}, 128'd0);
        check("R11", out_data, 128'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // Table walk: back-to-back valid inputs, each result one cycle later.
        for (int i = 0; i < NV; i++) begin
            drive(VECS[i]);
            in_valid = 1'b1;
            @(negedge clk);
            check("R11", {127'd0, out_valid}, 128'd1);
            check(tag_of(VECS[i].op), out_data, VECS[i].exp);
        end

        // R11 no valid in, no valid out
        in_valid = 1'b0;
        @(negedge clk);
        check("R11", {127'd0, out_valid}, 128'd0);

        // R11 reset during a valid input clears the output
        drive(VECS[0]);
        in_valid = 1'b1;
        rst_n = 1'b0;
        @(negedge clk);
        check("R11", {127'd0, out_valid}, 128'd0);
        check("R11", out_data, 128'd0);

        // R11 after release the same input emerges one cycle later
        rst_n = 1'b1;
        @(negedge clk);
        check("R11", {127'd0, out_valid}, 128'd1);
        check("R1", out_data, VECS[0].exp);
        in_valid = 1'b0;

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule